// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer/Counter

This block is an 8-bit timer with two compare channels, A and B. A count register steps once per timer event. The timer event comes from one of three sources: a prescaler tick input, a selected edge of an external pin, or nothing at all, in which case the counter is stopped. On every timer event the current count is compared with the active value of each channel. A hit raises that channel's flag, flips that channel's toggle output and, if the channel is unmasked, drives its interrupt line.

Software writes a compare value into a buffer. The counter copies both buffers into the active compare registers only at the end of a counting period, so a write never changes a period that is already running. The counter runs in one of two ways:
- Normal mode: the counter counts up and restarts at zero after its terminal value.
- Up/down mode: the counter turns around at the terminal value and again at zero.

The terminal value is either the all-ones count or the active channel-A value.

All configuration goes through one address/data port. Writes are synchronous. Reads are combinational on the same address lines.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, every readable register (addresses 0 to 5) reads zero, and all interrupt and toggle outputs are low.
- R2: Control register (address 0) bits [2:0] select the event source. 0 stops the counter, and the count then holds its value. Values 1 to 5 count on each cycle with `presTick` high. 6 counts on falling edges of `extPin`, and 7 counts on rising edges.
- R3: A selected `extPin` transition made between clock edges advances the count at the third rising clock edge after it. Each transition produces exactly one step.
- R4: Normal mode (control bit 4 = 0): on an event with count >= terminal value, the count becomes 0 and overflow flag bit 2 (flags, address 5) is set. Otherwise the count increases by one.
- R5: Control bit 3 selects the terminal value: 0 gives 0xFF, and 1 gives the active channel-A compare value.
- R6: Up/down mode (control bit 4 = 1): counting upward, an event at count >= terminal value turns the direction down. Counting downward, an event at count 0 turns the direction up and sets overflow flag bit 2. Any write to the control register restarts the direction upward.
- R7: Writes to addresses 2 (A) and 3 (B) go to buffers, which read back at once. The active compare values take the buffer contents only on the wrap to zero in normal mode, or on the turn at zero in up/down mode.
- R8: On an event whose pre-step count equals a channel's active compare value, that channel's flag is set (bit 0 for A, bit 1 for B) and its toggle output inverts.
- R9: Each interrupt output is high exactly while its flag bit and the same bit of the mask register (address 4) are both 1.
- R10: Writing 1 to a flag bit at address 5 clears it, and writing 0 leaves it alone. When a hardware set and a clear land on the same edge, the flag stays set.
- R11: A write to address 1 loads the count and overrides any step on that edge. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address for read and write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` |
| presTick | input | 1 | Prescaled internal tick, one cycle wide |
| extPin | input | 1 | External count pin, asynchronous |
| irqA | output | 1 | Channel A interrupt request |
| irqB | output | 1 | Channel B interrupt request |
| irqOvf | output | 1 | Overflow/bottom interrupt request |
| toggleA | output | 1 | Inverts on each channel A match |
| toggleB | output | 1 | Inverts on each channel B match |

## Verification
Register writes, count steps, flag sets, toggles and buffer loads all appear one edge after the cycle that carries the write or the event. Interrupt lines follow flags and mask in the same cycle. An external pin transition reaches the count on the third edge.

The bench drives every input just after a falling edge and compares all outputs at the next falling edge. Its reference model advances on each rising edge from the inputs it drove, so every result is compared in the cycle it is due. Pin activity is passed through a modelled two-stage delay before it becomes a count event.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int ADDR_W = 3;
  localparam int FLAG_W = 3;
  localparam int CTL_W  = 5;

  localparam logic [ADDR_W-1:0] REG_CTL  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_BUFA = 3'd2;
  localparam logic [ADDR_W-1:0] REG_BUFB = 3'd3;
  localparam logic [ADDR_W-1:0] REG_MASK = 3'd4;
  localparam logic [ADDR_W-1:0] REG_FLAG = 3'd5;

  localparam int FLAG_A   = 0;
  localparam int FLAG_B   = 1;
  localparam int FLAG_OVF = 2;

  localparam logic [2:0] SRC_OFF      = 3'd0;
  localparam logic [2:0] SRC_EXT_FALL = 3'd6;
  localparam logic [2:0] SRC_EXT_RISE = 3'd7;

  typedef struct packed {
    logic tick;
    logic stepUp;
    logic stepDown;
    logic wrapZero;
    logic loadCmp;
    logic ovfEvt;
  } tmrStrobe_t;
endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
#(
  parameter int CntW      = 8,
  parameter int SyncDepth = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctlWr,
  input  logic [CTL_W-1:0] ctlData,
  input  logic            presTick,
  input  logic            extPin,
  input  logic [CntW-1:0] count,
  input  logic [CntW-1:0] actA,
  output logic [CTL_W-1:0] ctlQ,
  output tmrStrobe_t      strb
);
  localparam logic [CntW-1:0] CntMax = {CntW{1'b1}};

  logic [SyncDepth:0] syncQ;
  logic               dirDown;
  logic [2:0]         clkSel;
  logic               topFromA;
  logic               upDown;
  logic [CntW-1:0]    topVal;
  logic               pinRise;
  logic               pinFall;
  logic               tick;
  logic               atTop;
  logic               atBottom;

  assign clkSel   = ctlQ[2:0];
  assign topFromA = ctlQ[3];
  assign upDown   = ctlQ[4];
  assign topVal   = topFromA ? actA : CntMax;
  assign atTop    = (count >= topVal);
  assign atBottom = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SyncDepth-1:0], extPin};
  end

  assign pinRise =  syncQ[SyncDepth-1] & ~syncQ[SyncDepth];
  assign pinFall = ~syncQ[SyncDepth-1] &  syncQ[SyncDepth];

  always_comb begin
    case (clkSel)
      SRC_OFF:      tick = 1'b0;
      SRC_EXT_FALL: tick = pinFall;
      SRC_EXT_RISE: tick = pinRise;
      default:      tick = presTick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      ctlQ <= '0;
    else if (ctlWr) ctlQ <= ctlData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctlWr) dirDown <= 1'b0;
    else if (tick && upDown) begin
      if (!dirDown && atTop)         dirDown <= 1'b1;
      else if (dirDown && atBottom)  dirDown <= 1'b0;
    end
  end

  always_comb begin
    strb      = '0;
    strb.tick = tick;
    if (tick) begin
      if (!upDown) begin
        if (atTop) begin
          strb.wrapZero = 1'b1;
          strb.loadCmp  = 1'b1;
          strb.ovfEvt   = 1'b1;
        end else begin
          strb.stepUp = 1'b1;
        end
      end else if (!dirDown) begin
        if (atTop) strb.stepDown = !atBottom;
        else       strb.stepUp   = 1'b1;
      end else begin
        if (atBottom) begin
          strb.loadCmp = 1'b1;
          strb.ovfEvt  = 1'b1;
          strb.stepUp  = (topVal != '0);
        end else begin
          strb.stepDown = 1'b1;
        end
      end
    end
  end

  // R6
  bottom_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && upDown && dirDown && atBottom && !ctlWr) |=> !dirDown);

  // R6
  ctl_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> !dirDown);
endmodule

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
#(
  parameter int CntW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [CntW-1:0]   wrData,
  output logic [CntW-1:0]   count,
  output logic [CntW-1:0]   bufA,
  output logic [CntW-1:0]   bufB,
  output logic [CntW-1:0]   actA,
  output logic [FLAG_W-1:0] maskQ,
  output logic [FLAG_W-1:0] flagQ,
  output logic              togA,
  output logic              togB
);
  logic [CntW-1:0]   actB;
  logic              cntWr;
  logic              flagWr;
  logic              hitA;
  logic              hitB;
  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] clrVec;

  assign cntWr  = wrEn && (addr == REG_CNT);
  assign flagWr = wrEn && (addr == REG_FLAG);
  assign hitA   = strb.tick && (count == actA);
  assign hitB   = strb.tick && (count == actB);

  always_comb begin
    setVec           = '0;
    setVec[FLAG_A]   = hitA;
    setVec[FLAG_B]   = hitB;
    setVec[FLAG_OVF] = strb.ovfEvt;
    clrVec           = flagWr ? wrData[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              count <= '0;
    else if (cntWr)         count <= wrData;
    else if (strb.wrapZero) count <= '0;
    else if (strb.stepUp)   count <= count + CntW'(1);
    else if (strb.stepDown) count <= count - CntW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufA <= '0;
      bufB <= '0;
      actA <= '0;
      actB <= '0;
    end else begin
      if (strb.loadCmp) begin
        actA <= bufA;
        actB <= bufB;
      end
      if (wrEn && addr == REG_BUFA) bufA <= wrData;
      if (wrEn && addr == REG_BUFB) bufB <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      flagQ <= '0;
      togA  <= 1'b0;
      togB  <= 1'b0;
    end else begin
      if (wrEn && addr == REG_MASK) maskQ <= wrData[FLAG_W-1:0];
      flagQ <= (flagQ & ~clrVec) | setVec;
      togA  <= togA ^ hitA;
      togB  <= togB ^ hitB;
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !cntWr) |=> (count == $past(count)));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrapZero && !cntWr) |=> (count == '0));

  // R8
  match_flag_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && count == actA) |=> flagQ[FLAG_A]);

  // R10
  clear_flag_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWr && wrData[FLAG_A] && !(strb.tick && count == actA)) |=> !flagQ[FLAG_A]);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int CntW      = 8,
  parameter int SyncDepth = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [CntW-1:0]   wrData,
  output logic [CntW-1:0]   rdData,
  input  logic              presTick,
  input  logic              extPin,
  output logic              irqA,
  output logic              irqB,
  output logic              irqOvf,
  output logic              toggleA,
  output logic              toggleB
);
  tmrStrobe_t        strb;
  logic [CTL_W-1:0]  ctlQ;
  logic [CntW-1:0]   count;
  logic [CntW-1:0]   bufA;
  logic [CntW-1:0]   bufB;
  logic [CntW-1:0]   actA;
  logic [FLAG_W-1:0] maskQ;
  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] irqVec;

  dct_ctrl #(.CntW(CntW), .SyncDepth(SyncDepth)) ctrlUnit (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWr    (wrEn && addr == REG_CTL),
    .ctlData  (wrData[CTL_W-1:0]),
    .presTick (presTick),
    .extPin   (extPin),
    .count    (count),
    .actA     (actA),
    .ctlQ     (ctlQ),
    .strb     (strb)
  );

  dct_datapath #(.CntW(CntW)) dataUnit (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .count  (count),
    .bufA   (bufA),
    .bufB   (bufB),
    .actA   (actA),
    .maskQ  (maskQ),
    .flagQ  (flagQ),
    .togA   (toggleA),
    .togB   (toggleB)
  );

  assign irqVec = flagQ & maskQ;
  assign irqA   = irqVec[FLAG_A];
  assign irqB   = irqVec[FLAG_B];
  assign irqOvf = irqVec[FLAG_OVF];

  always_comb begin
    rdData = '0;
    case (addr)
      REG_CTL:  rdData[CTL_W-1:0]  = ctlQ;
      REG_CNT:  rdData             = count;
      REG_BUFA: rdData             = bufA;
      REG_BUFB: rdData             = bufB;
      REG_MASK: rdData[FLAG_W-1:0] = maskQ;
      REG_FLAG: rdData[FLAG_W-1:0] = flagQ;
      default:  rdData             = '0;
    endcase
  end
endmodule

// File: tb/dual_cmp_timer_test.sv
module dual_cmp_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       presTick = 1'b0;
  logic       extPin = 1'b0;
  logic       irqA, irqB, irqOvf, toggleA, toggleB;

  int nChk = 0;
  int nFail = 0;
  string phase = "R1";

  // behavioural reference state
  int mCtl, mCnt, mDir, mA, mB, mBufA, mBufB, mMask, mFlags, mTogA, mTogB;
  int s1, s2, s3;
  int sel, top, ud, tk, setA, setB, setO, ld, nCnt, nDir, clr, nA, nB;

  dual_cmp_timer uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .presTick(presTick), .extPin(extPin),
    .irqA(irqA), .irqB(irqB), .irqOvf(irqOvf),
    .toggleA(toggleA), .toggleB(toggleB)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtl = 0; mCnt = 0; mDir = 0; mA = 0; mB = 0; mBufA = 0; mBufB = 0;
      mMask = 0; mFlags = 0; mTogA = 0; mTogB = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      sel = mCtl % 8;
      if (sel == 0) tk = 0;
      else if (sel == 6) tk = (s2 == 0 && s3 == 1);
      else if (sel == 7) tk = (s2 == 1 && s3 == 0);
      else tk = presTick;
      top = ((mCtl / 8) % 2 == 1) ? mA : 255;
      ud  = (mCtl / 16) % 2;
      setA = tk && (mCnt == mA);
      setB = tk && (mCnt == mB);
      setO = 0; ld = 0; nCnt = mCnt; nDir = mDir; clr = 0;
      if (tk) begin
        if (ud == 0) begin
          if (mCnt >= top) begin nCnt = 0; setO = 1; ld = 1; end
          else nCnt = mCnt + 1;
        end else if (mDir == 0) begin
          if (mCnt >= top) begin nDir = 1; if (mCnt > 0) nCnt = mCnt - 1; end
          else nCnt = mCnt + 1;
        end else begin
          if (mCnt == 0) begin nDir = 0; setO = 1; ld = 1; if (top > 0) nCnt = 1; end
          else nCnt = mCnt - 1;
        end
      end
      nA = ld ? mBufA : mA;
      nB = ld ? mBufB : mB;
      if (wrEn) begin
        case (addr)
          3'd0: begin mCtl = wrData % 32; nDir = 0; end
          3'd1: nCnt = wrData;
          3'd2: mBufA = wrData;
          3'd3: mBufB = wrData;
          3'd4: mMask = wrData % 8;
          3'd5: clr = wrData % 8;
          default: ;
        endcase
      end
      mA = nA; mB = nB; mCnt = nCnt; mDir = nDir;
      mFlags = (mFlags & ~clr & 7) | (setO * 4) | (setB * 2) | setA;
      mTogA = mTogA ^ setA;
      mTogB = mTogB ^ setB;
      s3 = s2; s2 = s1; s1 = extPin;
    end
  end

  function automatic int expRd(input int a);
    case (a)
      0: return mCtl;
      1: return mCnt;
      2: return mBufA;
      3: return mBufB;
      4: return mMask;
      5: return mFlags;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    chk((addr == 3'd5) ? "R10" : (addr >= 3'd6) ? "R11" : phase, int'(rdData), expRd(int'(addr)));
    chk("R9", int'(irqA),   (mFlags & mMask) % 2);
    chk("R9", int'(irqB),   ((mFlags & mMask) / 2) % 2);
    chk("R9", int'(irqOvf), ((mFlags & mMask) / 4) % 2);
    chk("R8", int'(toggleA), mTogA);
    chk("R8", int'(toggleB), mTogB);
  endtask

  task automatic cyc(input int a, input int w, input int d, input int t);
    @(negedge clk);
    compareAll();
    addr = 3'(a); wrEn = 1'(w); wrData = 8'(d); presTick = 1'(t);
  endtask

  task automatic run(input int n, input int a, input int t);
    for (int i = 0; i < n; i++) cyc(a, 0, 0, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog: actual 100000 cycles, expected completion earlier");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    // R1: reset values on every address
    for (int a = 0; a < 8; a++) cyc(a, 0, 0, 1);
    @(negedge clk); rstN = 1'b1;
    for (int a = 0; a < 8; a++) cyc(a, 0, 0, 1);

    // R7: buffered writes read back at once, active copy untouched
    phase = "R7";
    cyc(2, 1, 40, 0); cyc(3, 1, 10, 0); cyc(4, 1, 7, 0);
    run(2, 2, 0); run(2, 3, 0);

    // R2: source selected but no tick, then stopped source with ticks
    phase = "R2";
    cyc(0, 1, 1, 0); run(10, 1, 0);
    cyc(0, 1, 0, 1); run(10, 1, 1);

    // R4: normal mode through a full wrap, loads at wrap
    phase = "R4";
    cyc(0, 1, 1, 1);
    for (int i = 0; i < 300; i++) cyc((i % 4 == 3) ? 5 : 1, 0, 0, 1);

    // R10: clear every cycle while matches land on the same edges
    phase = "R10";
    for (int i = 0; i < 60; i++) cyc(5, 1, 7, 1);
    run(4, 5, 0);

    // R5: terminal value from channel A, then reload A mid-run (R7)
    phase = "R5";
    cyc(0, 1, 9, 1);
    run(100, 1, 1);
    cyc(2, 1, 25, 1);
    for (int i = 0; i < 100; i++) cyc((i % 5 == 0) ? 5 : 1, 0, 0, 1);

    // R6: up/down with A as terminal, irregular ticks
    phase = "R6";
    cyc(0, 1, 25, 1);
    for (int i = 0; i < 200; i++) cyc((i % 6 == 0) ? 5 : 1, 0, 0, ($urandom_range(0, 3) != 0));
    cyc(0, 1, 17, 1);
    run(80, 1, 1);

    // R11: count load overrides a step; unused addresses read zero
    phase = "R11";
    cyc(0, 1, 1, 1);
    cyc(1, 1, 200, 1);
    run(70, 1, 1);
    cyc(1, 1, 3, 1);
    run(3, 6, 1); run(3, 7, 1); run(5, 1, 1);

    // R3: external pin, rising then falling edge selection
    phase = "R3";
    cyc(0, 1, 7, 0);
    for (int i = 0; i < 120; i++) begin
      if (i % 5 == 0) extPin = ~extPin;
      cyc(1, 0, 0, 1);
    end
    cyc(0, 1, 6, 0);
    for (int i = 0; i < 120; i++) begin
      if (i % 7 == 0) extPin = ~extPin;
      cyc(1, 0, 0, 0);
    end

    // R9: random masks, clears and ticks
    phase = "R9";
    cyc(0, 1, 1, 1); cyc(2, 1, 5, 1); cyc(3, 1, 9, 1);
    cyc(0, 1, 9, 1);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 9);
      if (r == 0)      cyc(4, 1, $urandom_range(0, 7), 1);
      else if (r == 1) cyc(5, 1, $urandom_range(0, 7), 1);
      else             cyc($urandom_range(0, 5), 0, 0, $urandom_range(0, 1));
    end

    @(negedge clk);
    compareAll();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule